// File: doc/BRIEF.md
# In-Order Retire Queue with Latency Delay and Squash

The block is the back end of a simple in-order core. Each cycle the front end offers up to `W` instructions on parallel lanes. Each instruction carries a sequence number, a PC, a redirect-target PC, a destination-register count, a memory-reference flag and a mispredict flag. Accepted instructions enter a circular queue. The per-cycle insertion count is written into a delay line that is `LAT+1` slots deep. The count that reaches the far end of the delay line is the number of instructions due to retire in that cycle.

Due instructions retire in order from the head of the queue. A due memory reference that sees a data-cache miss stops the queue. When the fill arrives, that same instruction retires without being issued again. A retiring mispredicted instruction redirects the front end at its own sequence number. An external squash request removes everything in flight on the following cycle. Every squash flushes the delay line and reports the destination registers it frees.

`DEPTH` must be a power of two and `LAT` at least 1. Sequence numbers are compared as unsigned values with no wraparound, so the front end keeps them rising and nonzero.

Top module: `inorder_retire_q`

## Requirements
- R1: `in_take_o` accepts the leading run of set bits in `in_vld_i`, counted from lane 0. The count is capped at `W` minus what the newest delay-line slot already holds, and by the free queue space. `in_vld_i=2'b10` accepts nothing.
- R2: With no stall or squash, an instruction accepted in cycle t retires in cycle t+`LAT`. Instructions retire in acceptance order on lanes filled from lane 0 (`ret_vld_o` bit k, with `ret_seq_o[k]` and `ret_pc_o[k]`).
- R3: While the queue is stalled on a miss, `in_take_o` is 0 and nothing retires.
- R4: A due memory reference is checked against `dmiss_i` in that cycle. If `dmiss_i` is high, the reference and all later due instructions stay held. A later `dfill_i` ends the stall, and the held reference then retires in the next cycle whatever `dmiss_i` is.
- R5: Each retiring instruction adds its destination-register count to `freed_o` in its retire cycle.
- R6: A retiring instruction with its mispredict flag set raises `redir_vld_o` in that cycle, with `redir_seq_o` equal to its own sequence number and `redir_pc_o` equal to its redirect target. In the same cycle:
  - no later lane retires and nothing is accepted;
  - every queued entry with a larger sequence number is removed, and its destination count is added to `freed_o`;
  - nothing already accepted retires afterwards.
- R7: A pulse on `sq_req_i` starts a squash one cycle later. That cycle raises `redir_vld_o` with `redir_pc_o` = `sq_pc_i`. `redir_seq_o` is the oldest entry's sequence number minus one, or 0 if the queue is empty. All entries with larger sequence numbers are removed and their destination counts are summed into `freed_o`. Nothing they held retires afterwards.
- R8: In the cycle a requested squash is carried out, nothing retires and nothing is accepted, even if instructions are due. A pending miss stall is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | W | Lane valid from the front end |
| in_seq_i | input | W*SEQ_W | Sequence number per lane |
| in_pc_i | input | W*PC_W | PC per lane |
| in_npc_i | input | W*PC_W | Redirect-target PC per lane |
| in_dst_i | input | W*DST_W | Destination-register count per lane |
| in_mem_i | input | W | Memory-reference flag per lane |
| in_mp_i | input | W | Mispredict flag per lane |
| in_take_o | output | $clog2(W+1) | Number of lanes accepted this cycle |
| dmiss_i | input | 1 | Data-cache miss for a due memory reference |
| dfill_i | input | 1 | Miss completion |
| sq_req_i | input | 1 | External squash request |
| sq_pc_i | input | PC_W | Redirect PC for the external squash |
| ret_vld_o | output | W | Retire valid per lane |
| ret_seq_o | output | W*SEQ_W | Retired sequence numbers |
| ret_pc_o | output | W*PC_W | Retired PCs |
| freed_o | output | FW | Destination registers freed this cycle |
| redir_vld_o | output | 1 | Front-end redirect valid |
| redir_seq_o | output | SEQ_W | Squash sequence number |
| redir_pc_o | output | PC_W | Redirect target PC |

## Verification
Four corner cases get directed scenarios; each lists the wrong behaviour it would expose.
- Miss followed by fill with more work already queued behind it. A design that re-checks `dmiss_i` after the fill would stall forever. One that keeps accepting during the stall, or ignores the full newest delay-line slot when the fill lands, would overfill that slot.
- Mispredict on lane 0 with a younger due instruction on lane 1 and a third entry still in flight. A design that lets lane 1 retire, or leaves the delay line live, would retire squashed work. One that skips the squashed destination counts would leak registers.
- External squash landing in the cycle where instructions are due. A design that lets the squash cycle retire would commit past the redirect.
- External squash on an empty queue. This one must report sequence number 0.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_MISS = 2'd1,
    ST_DONE = 2'd2
  } iq_state_e;
endpackage

// File: rtl/iq_delay_line.sv
module iq_delay_line #(
  parameter int W   = 2,
  parameter int LAT = 2,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] add_i,
  input  logic [CW-1:0] ret_i,
  input  logic          hold_i,
  input  logic          flush_i,
  output logic [CW-1:0] tail_o,
  output logic [CW-1:0] due_o
);
  logic [CW-1:0] slot_q [LAT+1];
  logic [CW-1:0] slot_d [LAT+1];

  always_comb begin
    slot_d = slot_q;
    slot_d[LAT] = slot_q[LAT] + add_i;
    slot_d[0] = slot_d[0] - ret_i;
    // advance only once every due instruction has gone
    if (slot_d[0] == '0) begin
      for (int i = 0; i < LAT; i++) slot_d[i] = slot_d[i+1];
      slot_d[LAT] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= LAT; i++) slot_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i <= LAT; i++) slot_q[i] <= '0;
    end else if (!hold_i) begin
      slot_q <= slot_d;
    end
  end

  assign tail_o = slot_q[LAT];
  assign due_o  = slot_q[0];

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (due_o == '0 && tail_o == '0)); // R7
endmodule

// File: rtl/iq_squash_scan.sv
module iq_squash_scan #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int DST_W = 2,
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(DEPTH * ((1 << DST_W) - 1) + 1)
) (
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  input  logic [DEPTH-1:0][DST_W-1:0] dst_i,
  input  logic [PW-1:0]               head_i,
  input  logic [NW-1:0]               cnt_i,
  input  logic [SEQ_W-1:0]            lim_i,
  output logic [NW-1:0]               keep_o,
  output logic [FW-1:0]               free_o
);
  logic [DEPTH-1:0] live, kill;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PW-1:0] rel;
    assign rel     = PW'(g) - head_i;
    assign live[g] = NW'(rel) < cnt_i;
    assign kill[g] = live[g] && (seq_i[g] > lim_i);
  end

  always_comb begin
    keep_o = '0;
    free_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && !kill[i]) keep_o = keep_o + NW'(1);
      if (kill[i]) free_o = free_o + FW'(dst_i[i]);
    end
  end
endmodule

// File: rtl/inorder_retire_q.sv
module inorder_retire_q
  import iq_pkg::*;
#(
  parameter int W     = 2,
  parameter int LAT   = 2,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int DST_W = 2,
  localparam int CW = $clog2(W + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(DEPTH * ((1 << DST_W) - 1) + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              in_vld_i,
  input  logic [W-1:0][SEQ_W-1:0]   in_seq_i,
  input  logic [W-1:0][PC_W-1:0]    in_pc_i,
  input  logic [W-1:0][PC_W-1:0]    in_npc_i,
  input  logic [W-1:0][DST_W-1:0]   in_dst_i,
  input  logic [W-1:0]              in_mem_i,
  input  logic [W-1:0]              in_mp_i,
  output logic [CW-1:0]             in_take_o,
  input  logic                      dmiss_i,
  input  logic                      dfill_i,
  input  logic                      sq_req_i,
  input  logic [PC_W-1:0]           sq_pc_i,
  output logic [W-1:0]              ret_vld_o,
  output logic [W-1:0][SEQ_W-1:0]   ret_seq_o,
  output logic [W-1:0][PC_W-1:0]    ret_pc_o,
  output logic [FW-1:0]             freed_o,
  output logic                      redir_vld_o,
  output logic [SEQ_W-1:0]          redir_seq_o,
  output logic [PC_W-1:0]           redir_pc_o
);
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0][DST_W-1:0] dst_q;
  logic [DEPTH-1:0][PC_W-1:0]  pc_q, npc_q;
  logic [DEPTH-1:0]            mem_q, mp_q;
  logic [PW-1:0]               head_q;
  logic [NW-1:0]               cnt_q;
  iq_state_e                   st_q;
  logic                        pend_q;
  logic [PC_W-1:0]             pend_pc_q;

  logic [CW-1:0]    tail, due, n_ret, lv, take;
  logic             run_ok, go, stall_hit, mp_hit, flush;
  logic [SEQ_W-1:0] mp_seq, sq_lim;
  logic [PC_W-1:0]  mp_pc;
  logic [FW-1:0]    ret_free, sq_free;
  logic [NW-1:0]    keep;
  logic [PW-1:0]    wr_idx [W];

  assign run_ok = !pend_q && (st_q != ST_MISS);

  // in-order retirement of the due group
  always_comb begin
    logic [PW-1:0] idx;
    ret_vld_o = '0;
    ret_seq_o = '0;
    ret_pc_o  = '0;
    n_ret     = '0;
    ret_free  = '0;
    mp_hit    = 1'b0;
    mp_seq    = '0;
    mp_pc     = '0;
    stall_hit = 1'b0;
    go        = run_ok;
    for (int k = 0; k < W; k++) begin
      idx = head_q + PW'(k);
      if (go && (CW'(k) < due)) begin
        if (mem_q[idx] && dmiss_i && !(k == 0 && st_q == ST_DONE)) begin
          stall_hit = 1'b1;
          go        = 1'b0;
        end else begin
          ret_vld_o[k] = 1'b1;
          ret_seq_o[k] = seq_q[idx];
          ret_pc_o[k]  = pc_q[idx];
          n_ret        = n_ret + CW'(1);
          ret_free     = ret_free + FW'(dst_q[idx]);
          if (mp_q[idx]) begin
            mp_hit = 1'b1;
            mp_seq = seq_q[idx];
            mp_pc  = npc_q[idx];
            go     = 1'b0;
          end
        end
      end
    end
  end

  // acceptance: leading valid lanes, capped by slot and queue room
  always_comb begin
    logic run;
    run = 1'b1;
    lv  = '0;
    for (int j = 0; j < W; j++) begin
      run = run && in_vld_i[j];
      if (run) lv = lv + CW'(1);
    end
    take = lv;
    if (take > CW'(W) - tail) take = CW'(W) - tail;
    if (NW'(take) > NW'(DEPTH) - cnt_q) take = CW'(NW'(DEPTH) - cnt_q);
    if (!run_ok || mp_hit) take = '0;
  end
  assign in_take_o = take;

  for (genvar g = 0; g < W; g++) begin : g_wr
    assign wr_idx[g] = head_q + PW'(cnt_q) + PW'(g);
  end

  assign sq_lim = pend_q ? ((cnt_q == '0) ? '0 : seq_q[head_q] - SEQ_W'(1)) : mp_seq;
  assign flush  = pend_q || mp_hit;

  iq_squash_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DST_W(DST_W)) i_scan (
    .seq_i  (seq_q),
    .dst_i  (dst_q),
    .head_i (head_q),
    .cnt_i  (cnt_q),
    .lim_i  (sq_lim),
    .keep_o (keep),
    .free_o (sq_free)
  );

  iq_delay_line #(.W(W), .LAT(LAT)) i_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .add_i   (take),
    .ret_i   (n_ret),
    .hold_i  (st_q == ST_MISS),
    .flush_i (flush),
    .tail_o  (tail),
    .due_o   (due)
  );

  assign freed_o     = pend_q ? sq_free : ret_free + (mp_hit ? sq_free : '0);
  assign redir_vld_o = flush;
  assign redir_seq_o = sq_lim;
  assign redir_pc_o  = pend_q ? pend_pc_q : mp_pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_pc_q <= '0;
      head_q    <= '0;
      cnt_q     <= '0;
      st_q      <= ST_RUN;
    end else begin
      pend_q    <= sq_req_i;
      pend_pc_q <= sq_pc_i;
      if (pend_q) begin
        cnt_q <= keep;
        st_q  <= ST_RUN;
      end else if (st_q == ST_MISS) begin
        if (dfill_i) st_q <= ST_DONE;
      end else begin
        head_q <= head_q + PW'(n_ret);
        cnt_q  <= mp_hit ? keep - NW'(n_ret) : cnt_q + NW'(take) - NW'(n_ret);
        if (stall_hit)          st_q <= ST_MISS;
        else if (n_ret != '0)   st_q <= ST_RUN;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < W; j++) begin
      if (CW'(j) < take) begin
        seq_q[wr_idx[j]] <= in_seq_i[j];
        pc_q[wr_idx[j]]  <= in_pc_i[j];
        npc_q[wr_idx[j]] <= in_npc_i[j];
        dst_q[wr_idx[j]] <= in_dst_i[j];
        mem_q[wr_idx[j]] <= in_mem_i[j];
        mp_q[wr_idx[j]]  <= in_mp_i[j];
      end
    end
  end

  AST_TAKE_LE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(in_take_o) <= $countones(in_vld_i)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(DEPTH)); // R1
  AST_RET_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld_o & W'(ret_vld_o + W'(1))) == '0); // R2
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MISS) |-> (in_take_o == '0 && ret_vld_o == '0)); // R3
  AST_MISS_HOLD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MISS) |=> $stable(head_q)); // R4
  AST_PEND_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (ret_vld_o == '0 && in_take_o == '0)); // R8
endmodule

// File: tb/test_inorder_retire_q.sv
module test_inorder_retire_q;
  localparam int CLK_P = 10;
  localparam int W = 2, SEQ_W = 16, PC_W = 32, DST_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0]            in_vld_i, in_mem_i, in_mp_i;
  logic [W-1:0][SEQ_W-1:0] in_seq_i;
  logic [W-1:0][PC_W-1:0]  in_pc_i, in_npc_i;
  logic [W-1:0][DST_W-1:0] in_dst_i;
  logic [1:0]              in_take_o;
  logic dmiss_i, dfill_i, sq_req_i;
  logic [PC_W-1:0]         sq_pc_i;
  logic [W-1:0]            ret_vld_o;
  logic [W-1:0][SEQ_W-1:0] ret_seq_o;
  logic [W-1:0][PC_W-1:0]  ret_pc_o;
  logic [4:0]              freed_o;
  logic                    redir_vld_o;
  logic [SEQ_W-1:0]        redir_seq_o;
  logic [PC_W-1:0]         redir_pc_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  inorder_retire_q i_inorder_retire_q (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
    in_vld_i = '0; in_mem_i = '0; in_mp_i = '0; in_seq_i = '0;
    in_pc_i = '0; in_npc_i = '0; in_dst_i = '0;
    dmiss_i = 1'b0; dfill_i = 1'b0; sq_req_i = 1'b0; sq_pc_i = '0;
  endtask

  task automatic offer(int l, int seq, int dst, bit mem, bit mp, int npc);
    in_vld_i[l] = 1'b1; in_seq_i[l] = SEQ_W'(seq); in_pc_i[l] = PC_W'(seq * 4);
    in_npc_i[l] = PC_W'(npc); in_dst_i[l] = DST_W'(dst);
    in_mem_i[l] = mem; in_mp_i[l] = mp;
  endtask

  task automatic t_reset();
    #1;
    chk("reset R2 ret_vld", int'(ret_vld_o), 0);
    chk("reset R7 redir", int'(redir_vld_o), 0);
    chk("reset R5 freed", int'(freed_o), 0);
    nxt();
  endtask

  task automatic t_basic();
    offer(0, 10, 1, 0, 0, 0); offer(1, 11, 2, 0, 0, 0); #1;
    chk("R1 take two", int'(in_take_o), 2); nxt();
    offer(0, 12, 0, 0, 0, 0); #1;
    chk("R1 take one", int'(in_take_o), 1); nxt();
    #1;
    chk("R2 retire pair", int'(ret_vld_o), 3);
    chk("R2 lane0 seq", int'(ret_seq_o[0]), 10);
    chk("R2 lane1 seq", int'(ret_seq_o[1]), 11);
    chk("R2 lane1 pc", int'(ret_pc_o[1]), 44);
    chk("R5 freed pair", int'(freed_o), 3); nxt();
    #1;
    chk("R2 retire third", int'(ret_vld_o), 1);
    chk("R2 third seq", int'(ret_seq_o[0]), 12);
    chk("R5 freed zero", int'(freed_o), 0); nxt();
    offer(1, 13, 0, 0, 0, 0); #1;
    chk("R1 gap lane0", int'(in_take_o), 0); nxt();
  endtask

  task automatic t_miss();
    offer(0, 20, 1, 1, 0, 0); offer(1, 21, 0, 0, 0, 0); #1;
    chk("R1 miss fill", int'(in_take_o), 2); nxt();
    nxt();
    dmiss_i = 1'b1; offer(0, 22, 0, 0, 0, 0); offer(1, 23, 0, 0, 0, 0); #1;
    chk("R4 stall no ret", int'(ret_vld_o), 0);
    chk("R1 take on stall", int'(in_take_o), 2); nxt();
    offer(0, 24, 0, 0, 0, 0); #1;
    chk("R3 no take", int'(in_take_o), 0);
    chk("R3 no ret", int'(ret_vld_o), 0); nxt();
    dfill_i = 1'b1; #1;
    chk("R3 fill cycle ret", int'(ret_vld_o), 0); nxt();
    dmiss_i = 1'b1; offer(0, 24, 0, 0, 0, 0); offer(1, 25, 0, 0, 0, 0); #1;
    chk("R4 held retires", int'(ret_vld_o), 3);
    chk("R4 held seq", int'(ret_seq_o[0]), 20);
    chk("R1 slot full", int'(in_take_o), 0);
    chk("R5 freed miss", int'(freed_o), 1); nxt();
    #1;
    chk("R2 gap after miss", int'(ret_vld_o), 0); nxt();
    #1;
    chk("R2 queued behind", int'(ret_vld_o), 3);
    chk("R2 queued seq", int'(ret_seq_o[1]), 23); nxt();
  endtask

  task automatic t_mispredict();
    offer(0, 30, 1, 0, 1, 'h400); offer(1, 31, 2, 0, 0, 0); #1; nxt();
    offer(0, 32, 3, 0, 0, 0); #1;
    chk("R1 take third", int'(in_take_o), 1); nxt();
    offer(0, 33, 0, 0, 0, 0); #1;
    chk("R6 only lane0", int'(ret_vld_o), 1);
    chk("R6 redir vld", int'(redir_vld_o), 1);
    chk("R6 redir seq", int'(redir_seq_o), 30);
    chk("R6 redir pc", int'(redir_pc_o), 'h400);
    chk("R6 freed", int'(freed_o), 6);
    chk("R6 no take", int'(in_take_o), 0); nxt();
    #1;
    chk("R6 quiet 1", int'(ret_vld_o), 0);
    chk("R6 redir drop", int'(redir_vld_o), 0); nxt();
    #1;
    chk("R6 quiet 2", int'(ret_vld_o), 0); nxt();
  endtask

  task automatic t_ext_squash();
    offer(0, 40, 1, 0, 0, 0); offer(1, 41, 1, 0, 0, 0); #1; nxt();
    sq_req_i = 1'b1; sq_pc_i = 'h800; offer(0, 42, 2, 0, 0, 0); #1;
    chk("R7 req cycle take", int'(in_take_o), 1);
    chk("R7 req cycle redir", int'(redir_vld_o), 0); nxt();
    offer(0, 43, 0, 0, 0, 0); #1;
    chk("R7 redir vld", int'(redir_vld_o), 1);
    chk("R7 redir seq", int'(redir_seq_o), 39);
    chk("R7 redir pc", int'(redir_pc_o), 'h800);
    chk("R7 freed", int'(freed_o), 4);
    chk("R8 no retire", int'(ret_vld_o), 0);
    chk("R8 no take", int'(in_take_o), 0); nxt();
    #1;
    chk("R7 flushed 1", int'(ret_vld_o), 0); nxt();
    #1;
    chk("R7 flushed 2", int'(ret_vld_o), 0); nxt();
    sq_req_i = 1'b1; sq_pc_i = 'h900; nxt();
    #1;
    chk("R7 empty seq", int'(redir_seq_o), 0);
    chk("R7 empty vld", int'(redir_vld_o), 1);
    chk("R7 empty freed", int'(freed_o), 0); nxt();
  endtask

  initial begin
    in_vld_i = '0; in_mem_i = '0; in_mp_i = '0; in_seq_i = '0;
    in_pc_i = '0; in_npc_i = '0; in_dst_i = '0;
    dmiss_i = 1'b0; dfill_i = 1'b0; sq_req_i = 1'b0; sq_pc_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_miss();
    t_mispredict();
    t_ext_squash();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule